// File: doc/BRIEF.md
# Periodic ALIGN Group Inserter

This block sits in the transmit path of a serial link, in front of scrambling and line coding. It passes a stream of 32-bit data words from an upstream valid/ready source to a downstream port that takes exactly one word per clock. At intervals it pauses the source and sends a group of ALIGN primitives, which let the far end hold its clock recovery. Every output word carries a primitive flag that marks control words.

Two configuration inputs set the spacing. An 8-bit rate value R places R-1 non-ALIGN words between consecutive groups. A mode bit selects groups of four ALIGNs instead of two. Rate values too small for the selected group size are raised to the smallest legal value. A data slot with no upstream word still consumes a word: a fill primitive is sent and counted. Configuration is sampled on the cycle that a group starts. That sample governs the group and the run of words that follows it, so a change never cuts a run short or stretches it.

Top module: `align_inserter`

## Requirements
- R1: With rate 0xFF the output carries exactly 254 non-ALIGN words between consecutive ALIGN groups.
- R2: For an effective rate R, exactly R-1 non-ALIGN words (data plus fill) are sent between consecutive groups.
- R3: A group is two consecutive ALIGN words when the four-ALIGN bit is 0, and four when it is 1. An ALIGN word is out_data = 32'h7B4A_4ABC with out_is_prim = 1.
- R4: The effective rate is raised to 3 when it is below 3 in two-ALIGN mode, and to 5 when it is below 5 in four-ALIGN mode.
- R5: in_ready is 0 for the whole of a group and 1 in every data slot. A word accepted at a rising edge (in_valid and in_ready both 1) appears on out_data after that edge with out_is_prim = 0. Accepted words appear once each and in order.
- R6: In a data slot with in_valid = 0, the fill word out_data = 32'h7C95_B5B5 with out_is_prim = 1 is sent after that edge, and it counts toward the R-1 words.
- R7: cfg_rate and cfg_quad are sampled only on the cycle of a group's first ALIGN. A change at any other time takes effect from the next group.
- R8: During reset out_data = 0, out_is_prim = 0 and in_ready = 0. The first words after reset form an ALIGN group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 8 | Rate setting R; R-1 words between groups |
| cfg_quad | input | 1 | 1 = four ALIGNs per group, 0 = two |
| in_data | input | 32 | Upstream data word |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Block accepts a word at this edge |
| out_data | output | 32 | Output word, one per cycle |
| out_is_prim | output | 1 | Output word is a control primitive |

## Verification
The stream is driven four ways: always valid, never valid, alternating, and pseudo-random. Always valid shows that data is neither lost nor repeated across group boundaries. Never valid shows that fill words count toward the interval. The alternating and random patterns show that the gap length does not depend on how data and fill mix. The rate is swept over 0xFF, mid values and sub-minimum values in both group modes, which separates the R-1 rule from the clamp. A change of the rate in the middle of a run separates sampling at the group start from sampling at any cycle.

// File: rtl/align_ins_pkg.sv
package align_ins_pkg;
  localparam int WORD_W = 32;
  localparam int RATE_W = 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RATE_W-1:0] rate_t;
  typedef enum logic {PH_GROUP = 1'b0, PH_DATA = 1'b1} phase_e;

  localparam word_t ALIGN_WORD = 32'h7B4A_4ABC;
  localparam word_t FILL_WORD  = 32'h7C95_B5B5;

  function automatic rate_t min_rate(input logic quad);
    return quad ? rate_t'(5) : rate_t'(3);
  endfunction

  function automatic rate_t clamp_rate(input rate_t r, input logic quad);
    return (r < min_rate(quad)) ? min_rate(quad) : r;
  endfunction

  function automatic rate_t group_len(input logic quad);
    return quad ? rate_t'(4) : rate_t'(2);
  endfunction
endpackage

// File: rtl/align_cfg_snap.sv
module align_cfg_snap
  import align_ins_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  rate_t cfg_rate,
  input  logic  cfg_quad,
  output rate_t eff_rate,
  output logic  eff_quad
);
  rate_t held_rate;
  logic  held_quad;

  assign eff_rate = capture ? clamp_rate(cfg_rate, cfg_quad) : held_rate;
  assign eff_quad = capture ? cfg_quad : held_quad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_rate <= rate_t'(255);
      held_quad <= 1'b0;
    end else if (capture) begin
      held_rate <= eff_rate;
      held_quad <= eff_quad;
    end
  end

  AST_EFF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    eff_rate >= min_rate(eff_quad)); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($past(eff_rate) == held_rate)); // R7
endmodule

// File: rtl/align_slot_seq.sv
module align_slot_seq
  import align_ins_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  rate_t eff_rate,
  input  logic  eff_quad,
  output logic  in_group,
  output logic  grp_start
);
  phase_e phase;
  rate_t  cnt;
  logic   grp_last;
  logic   run_last;

  assign in_group  = (phase == PH_GROUP);
  assign grp_start = in_group && (cnt == '0);
  assign grp_last  = in_group && (cnt == group_len(eff_quad) - rate_t'(1));
  assign run_last  = !in_group && (cnt == eff_rate - rate_t'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_GROUP;
      cnt   <= '0;
    end else if (grp_last) begin
      phase <= PH_DATA;
      cnt   <= '0;
    end else if (run_last) begin
      phase <= PH_GROUP;
      cnt   <= '0;
    end else begin
      cnt <= cnt + rate_t'(1);
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !in_group |-> (cnt <= eff_rate - rate_t'(2))); // R2
  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_group |-> (cnt < group_len(eff_quad))); // R3
endmodule

// File: rtl/align_word_mux.sv
module align_word_mux
  import align_ins_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_group,
  input  logic  in_valid,
  input  word_t in_data,
  output logic  xfer,
  output word_t out_data,
  output logic  out_is_prim
);
  assign xfer = !in_group && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data    <= '0;
      out_is_prim <= 1'b0;
    end else if (in_group) begin
      out_data    <= ALIGN_WORD;
      out_is_prim <= 1'b1;
    end else if (in_valid) begin
      out_data    <= in_data;
      out_is_prim <= 1'b0;
    end else begin
      out_data    <= FILL_WORD;
      out_is_prim <= 1'b1;
    end
  end

  AST_XFER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (out_data == $past(in_data)) && !out_is_prim); // R5
  AST_FILL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_group && !in_valid) |=> (out_data == FILL_WORD) && out_is_prim); // R6
endmodule

// File: rtl/align_inserter.sv
module align_inserter
  import align_ins_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_rate,
  input  logic        cfg_quad,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] out_data,
  output logic        out_is_prim
);
  rate_t eff_rate;
  logic  eff_quad;
  logic  in_group;
  logic  grp_start;
  logic  xfer;

  align_cfg_snap u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(grp_start),
    .cfg_rate(cfg_rate), .cfg_quad(cfg_quad),
    .eff_rate(eff_rate), .eff_quad(eff_quad)
  );

  align_slot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .eff_rate(eff_rate), .eff_quad(eff_quad),
    .in_group(in_group), .grp_start(grp_start)
  );

  align_word_mux u_mux (
    .clk(clk), .rst_n(rst_n), .in_group(in_group), .in_valid(in_valid),
    .in_data(in_data), .xfer(xfer), .out_data(out_data), .out_is_prim(out_is_prim)
  );

  assign in_ready = !in_group;

  // Output-side watch registers for the interval assertions
  logic out_align;
  logic prev_align;
  logic seen_group;
  logic [8:0] align_run;
  logic [8:0] gap_run;
  logic [8:0] last_grp;

  assign out_align = out_is_prim && (out_data == ALIGN_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_align <= 1'b0;
      seen_group <= 1'b0;
      align_run  <= '0;
      gap_run    <= '0;
      last_grp   <= '0;
    end else begin
      prev_align <= out_align;
      if (out_align) begin
        align_run <= prev_align ? align_run + 9'd1 : 9'd1;
      end else begin
        gap_run <= prev_align ? 9'd1 : gap_run + 9'd1;
        if (prev_align) begin
          last_grp   <= align_run;
          seen_group <= 1'b1;
        end
      end
    end
  end

  AST_READY_NO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && xfer) |=> !out_align); // R5
  AST_GROUP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_align && !out_align) |-> (align_run == 9'd2 || align_run == 9'd4)); // R3
  AST_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_group && out_align && !prev_align) |-> (gap_run <= 9'd254)); // R1
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_group && out_align && !prev_align) |->
      (gap_run >= ((last_grp == 9'd4) ? 9'd4 : 9'd2))); // R4
endmodule

// File: tb/test_align_inserter.sv
module test_align_inserter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALIGN_W = 32'h7B4A_4ABC;
  localparam logic [31:0] FILL_W  = 32'h7C95_B5B5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_rate;
  logic        cfg_quad;
  logic [31:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] out_data;
  logic        out_is_prim;

  align_inserter i_align_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_quad(cfg_quad),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_is_prim(out_is_prim)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R5";

  // reference model state
  int  pos = 0;
  int  m_grp = 2;
  int  m_rate = 255;
  bit  have_exp = 0;
  logic [31:0] exp_data;
  bit  exp_prim;
  logic [31:0] next_val = 32'h1000_0000;
  int  mode = 0;
  int  cyc = 0;

  // output watcher
  bit prev_a = 0;
  bit seen = 0;
  int grp = 0;
  int gap = 0;
  int last_gap = 0;
  int last_grp = 0;
  int gap_events = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int clamp(input int r, input bit q);
    int lo;
    lo = q ? 5 : 3;
    return (r < lo) ? lo : r;
  endfunction

  task automatic step();
    bit a;
    bit exp_ready;
    @(negedge clk);
    cyc++;
    if (have_exp) begin
      chk(out_data == exp_data && out_is_prim == exp_prim, cur_req,
          "output word", out_data, exp_data);
    end
    a = out_is_prim && (out_data == ALIGN_W);
    if (a) begin
      if (!prev_a) begin
        if (seen) begin last_gap = gap; gap_events++; end
        grp = 1;
      end else grp++;
    end else begin
      if (prev_a) begin last_grp = grp; seen = 1; gap = 1; end
      else gap++;
    end
    prev_a = a;

    case (mode)
      0: in_valid = 1'b1;
      1: in_valid = 1'b0;
      2: in_valid = 1'($urandom % 2);
      default: in_valid = 1'(cyc % 2);
    endcase
    in_data = next_val;

    if (pos == 0) begin
      m_rate = clamp(int'(cfg_rate), cfg_quad);
      m_grp  = cfg_quad ? 4 : 2;
    end
    exp_ready = (pos >= m_grp);
    chk(in_ready == exp_ready, "R5", "in_ready", {31'b0, in_ready}, {31'b0, exp_ready});
    have_exp = 1;
    if (!exp_ready) begin
      exp_data = ALIGN_W; exp_prim = 1'b1;
    end else if (in_valid) begin
      exp_data = next_val; exp_prim = 1'b0;
      next_val = next_val + 32'd1;
    end else begin
      exp_data = FILL_W; exp_prim = 1'b1;
    end
    pos++;
    if (pos == m_grp + m_rate - 1) pos = 0;
  endtask

  task automatic wait_gaps(input int n);
    int target;
    target = gap_events + n;
    while (gap_events < target) step();
  endtask

  task automatic gap_check(input string req, input int exp_gap, input int exp_grp);
    wait_gaps(2);
    chk(last_gap == exp_gap, req, "words between groups", last_gap, exp_gap);
    chk(last_grp == exp_grp, req, "ALIGNs per group", last_grp, exp_grp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_rate = 8'd10; cfg_quad = 1'b0;
    in_data = '0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(out_data == 32'h0, "R8", "reset out_data", out_data, 32'h0);
    chk(out_is_prim == 1'b0, "R8", "reset out_is_prim", {31'b0, out_is_prim}, 32'h0);
    chk(in_ready == 1'b0, "R8", "reset in_ready", {31'b0, in_ready}, 32'h0);
    rst_n = 1'b1;
    // first model step happens at this same negedge
    cur_req = "R8";
    mode = 0;
    in_valid = 1'b1; in_data = next_val;
    m_rate = clamp(10, 0); m_grp = 2;
    exp_ready = 0;
    chk(in_ready == 1'b0, "R8", "first slot is group", {31'b0, in_ready}, 32'h0);
    have_exp = 1; exp_data = ALIGN_W; exp_prim = 1'b1; pos = 1;
    @(negedge clk);
    chk(out_data == ALIGN_W && out_is_prim, "R8", "first word after reset",
        out_data, ALIGN_W);
    prev_a = 1; grp = 1;
    have_exp = 0;
    // resume model one half-cycle earlier: recompute expectation for this cycle
    in_data = next_val;
    exp_ready = (pos >= m_grp);
    chk(in_ready == exp_ready, "R5", "in_ready", {31'b0, in_ready}, {31'b0, exp_ready});
    have_exp = 1; exp_data = ALIGN_W; exp_prim = 1'b1;
    pos++;

    // R2 / R3: two-ALIGN mode, always valid
    cur_req = "R2";
    gap_check("R2", 9, 2);
    // R3: four-ALIGN mode, alternating valid
    cur_req = "R3"; mode = 3; cfg_quad = 1'b1;
    gap_check("R3", 9, 4);
    // R7: change rate in the middle of a run
    cur_req = "R7"; mode = 0; cfg_quad = 1'b0; cfg_rate = 8'd6;
    wait_gaps(2);
    while (!(in_ready && gap >= 2)) step();
    cfg_rate = 8'd12;
    wait_gaps(1);
    chk(last_gap == 5, "R7", "run in progress keeps old rate", last_gap, 5);
    wait_gaps(1);
    chk(last_gap == 11, "R7", "next run uses new rate", last_gap, 11);
    // R1: full rate, random valid
    cur_req = "R1"; mode = 2; cfg_rate = 8'hFF;
    gap_check("R1", 254, 2);
    // R4: clamps
    cur_req = "R4"; cfg_rate = 8'd0; cfg_quad = 1'b0;
    gap_check("R4", 2, 2);
    cfg_rate = 8'd3; cfg_quad = 1'b1;
    gap_check("R4", 4, 4);
    cfg_rate = 8'd5; cfg_quad = 1'b1;
    gap_check("R4", 4, 4);
    // R6: no upstream data, fill counts
    cur_req = "R6"; mode = 1; cfg_rate = 8'd7; cfg_quad = 1'b0;
    gap_check("R6", 6, 2);
    chk(out_data == FILL_W || out_data == ALIGN_W, "R6", "idle stream content",
        out_data, FILL_W);
    // R5: data continuity after a long mixed run
    cur_req = "R5"; mode = 2; cfg_rate = 8'd9;
    repeat (200) step();
    step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  bit exp_ready;
endmodule